// File: doc/BRIEF.md
# Partitioned Multiprocessor Interrupt Controller

This block is an APB-attached interrupt controller for a multiprocessor cluster that may be split into independent partitions. Inside it are four complete interrupt controller instances. Each instance has its own pending, mask and priority-group registers. All four sample one shared vector of interrupt lines, so every instance sees every event.

Each processor is connected at run time to exactly one instance through a pair of routing registers. The instance that a processor is routed to drives that processor's interrupt request number and receives its acknowledge. When several processors share an instance, they see the same request and any one of them can retire it. This gives symmetric operation inside a partition and isolation between partitions.

Software finds the number of instances in a capability/control register. That register also holds a one-way lock that freezes the routing until reset.

Top module: `mpic_top`

## Requirements
- R1: After reset, every pending, mask and group register is zero, every processor is routed to instance 0, the lock is clear and every `cpu_irl` field is 0.
- R2: The control register (offset 0x10 in any instance window) reads the instance count minus one (3) in bits [3:0] and the lock flag in bit 31. All other bits read 0.
- R3: Address bits [13:12] select the instance window. Within a window, the group register is at 0x00, pending (read-only) at 0x04, mask at 0x08 and the write-one-to-clear pending register at 0x0C. Bit n of each of these registers belongs to line n. A write to one window leaves the other instances unchanged.
- R4: A 1 on `irq_in[n]` (n = 1..15) sets pending bit n in all four instances at the next clock edge. `irq_in[0]` has no effect.
- R5: Each instance requests the highest-numbered line that is both pending and unmasked among the lines whose group bit is 1. If no such line exists, it requests the highest such line among the lines whose group bit is 0. If no line qualifies, it requests 0.
- R6: Routing register A (offset 0x14) holds processor c (c = 0..7) in bits [4c+3:4c]. Routing register B (offset 0x18) holds processor c+8 in the same way. Fields of processors that do not exist read 0. Each `cpu_irl` field (processor c in bits [4c+3:4c]) carries the request of the instance the processor is routed to.
- R7: A routing field written with a value above 3 keeps its previous value. The other fields of the same write still take effect.
- R8: When `cpu_ack[c]` is high at a clock edge, pending bit `cpu_ack_num` of processor c is cleared in the routed instance only. An acknowledge of number 0 clears nothing. A new event on the same line at the same edge wins, and the bit stays set.
- R9: Writing 1 to bit 31 of the control register sets the lock. While the lock is set, routing writes are ignored. Writing 0 does not clear the lock; only reset does.
- R10: Writing to the clear register (0x0C) clears the pending bits of that instance where the write data is 1. Writes to the pending register (0x04) have no effect.
- R11: Processors routed to the same instance receive the same request number, and an acknowledge from any one of them retires the line for all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | 14 | APB byte address; [13:12] pick the instance |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| irq_in | input | 16 | Shared interrupt event lines, bit 0 unused |
| cpu_ack | input | 4 | Per-processor acknowledge strobe |
| cpu_ack_num | input | 16 | Per-processor acknowledged line number, 4 bits each |
| cpu_irl | output | 16 | Per-processor requested line number, 4 bits each |

## Verification
The bound checker watches four things on every cycle. Events are recorded in every instance. An acknowledge removes its line from the routed instance unless a new event on that line arrives at the same edge. Any non-zero request names a line that is pending and unmasked in the routed instance. Once the lock is set, it and the routing stay frozen. The choice between the two priority groups, the rejection of out-of-range routing values and the address decode of the register windows are shown only by the bench. It compares every processor's request and register read-back with a reference model after directed corner cases and randomised traffic.

// File: rtl/mpic_pkg.sv
package mpic_pkg;

    localparam int LINE_W    = 16;
    localparam int NUM_W     = 4;
    localparam int FIELD_W   = 4;
    localparam int FIELDS_PR = 8;
    localparam int INST_LSB  = 12;

    typedef logic [LINE_W-1:0] linevec_t;
    typedef logic [NUM_W-1:0]  linenum_t;

    typedef enum logic [2:0] {
        OFS_GROUP = 3'd0,
        OFS_PEND  = 3'd1,
        OFS_MASK  = 3'd2,
        OFS_CLEAR = 3'd3,
        OFS_CTRL  = 3'd4,
        OFS_ROUTA = 3'd5,
        OFS_ROUTB = 3'd6
    } regsel_t;

    typedef struct packed {
        logic     group_we;
        logic     mask_we;
        logic     clear_we;
        linevec_t data;
    } inst_wr_t;

    function automatic linenum_t top_line(linevec_t v);
        linenum_t n;
        n = '0;
        for (int b = 1; b < LINE_W; b++) begin
            if (v[b]) n = linenum_t'(b);
        end
        return n;
    endfunction

    function automatic linenum_t arbitrate(linevec_t pend, linevec_t mask, linevec_t group);
        linevec_t live;
        linevec_t hi;
        live = pend & mask & ~linevec_t'(1);
        hi   = live & group;
        return (hi != '0) ? top_line(hi) : top_line(live);
    endfunction

    function automatic linevec_t line_onehot(linenum_t n);
        linevec_t v;
        v = '0;
        if (n != '0) v[n] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/mpic_inst.sv
module mpic_inst
    import mpic_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  inst_wr_t wr,
    input  linevec_t irq_in,
    input  linevec_t ack_clr,
    output linevec_t pend_q,
    output linevec_t mask_q,
    output linevec_t group_q,
    output linenum_t irl
);

    linevec_t sw_clr;
    linevec_t new_evt;

    assign sw_clr  = wr.clear_we ? wr.data : '0;
    assign new_evt = irq_in & ~linevec_t'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            mask_q  <= '0;
            group_q <= '0;
        end else begin
            if (wr.group_we) group_q <= wr.data & ~linevec_t'(1);
            if (wr.mask_we)  mask_q  <= wr.data & ~linevec_t'(1);
            pend_q <= (pend_q & ~ack_clr & ~sw_clr) | new_evt;
        end
    end

    assign irl = arbitrate(pend_q, mask_q, group_q);

endmodule

// File: rtl/mpic_route_regs.sv
module mpic_route_regs
    import mpic_pkg::*;
#(
    parameter int NINST = 4,
    parameter int NCPU  = 4,
    parameter int IW    = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [1:0]               rout_we,
    input  logic                     ctrl_we,
    input  logic [31:0]              wdata,
    output logic [NCPU-1:0][IW-1:0]  sel_q,
    output logic                     lock_q,
    output logic [1:0][31:0]         rout_rd
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            lock_q <= 1'b0;
        end else begin
            if (ctrl_we && wdata[31]) lock_q <= 1'b1;
            for (int c = 0; c < NCPU; c++) begin
                if (rout_we[c / FIELDS_PR] && !lock_q &&
                    int'(wdata[(c % FIELDS_PR)*FIELD_W +: FIELD_W]) < NINST) begin
                    sel_q[c] <= wdata[(c % FIELDS_PR)*FIELD_W +: IW];
                end
            end
        end
    end

    always_comb begin
        rout_rd = '0;
        for (int c = 0; c < NCPU; c++) begin
            rout_rd[c / FIELDS_PR][(c % FIELDS_PR)*FIELD_W +: FIELD_W] = FIELD_W'(sel_q[c]);
        end
    end

endmodule

// File: rtl/mpic_apb_dec.sv
module mpic_apb_dec
    import mpic_pkg::*;
#(
    parameter int NINST  = 4,
    parameter int IW     = 2,
    parameter int ADDR_W = 14
) (
    input  logic                    psel,
    input  logic                    penable,
    input  logic                    pwrite,
    input  logic [ADDR_W-1:0]       paddr,
    input  logic [31:0]             pwdata,
    input  linevec_t [NINST-1:0]    pend,
    input  linevec_t [NINST-1:0]    mask,
    input  linevec_t [NINST-1:0]    group,
    input  logic                    lock,
    input  logic [1:0][31:0]        rout_rd,
    output inst_wr_t [NINST-1:0]    inst_wr,
    output logic [1:0]              rout_we,
    output logic                    ctrl_we,
    output logic [31:0]             prdata
);

    logic [IW-1:0] idx;
    logic          mapped;
    logic          hit;
    logic          wr;
    regsel_t       ofs;

    assign idx    = paddr[INST_LSB +: IW];
    assign mapped = (paddr[INST_LSB-1:5] == '0) && (paddr[1:0] == 2'b00) && (int'(idx) < NINST);
    assign hit    = psel && mapped;
    assign wr     = hit && penable && pwrite;
    assign ofs    = regsel_t'(paddr[4:2]);

    always_comb begin
        inst_wr = '0;
        rout_we = '0;
        ctrl_we = 1'b0;
        prdata  = '0;
        for (int i = 0; i < NINST; i++) inst_wr[i].data = pwdata[LINE_W-1:0];
        if (hit) begin
            case (ofs)
                OFS_GROUP: begin
                    prdata = {16'b0, group[idx]};
                    inst_wr[idx].group_we = wr;
                end
                OFS_PEND:  prdata = {16'b0, pend[idx]};
                OFS_MASK: begin
                    prdata = {16'b0, mask[idx]};
                    inst_wr[idx].mask_we = wr;
                end
                OFS_CLEAR: inst_wr[idx].clear_we = wr;
                OFS_CTRL: begin
                    prdata = {lock, 27'b0, 4'(NINST - 1)};
                    ctrl_we = wr;
                end
                OFS_ROUTA: begin
                    prdata = rout_rd[0];
                    rout_we[0] = wr;
                end
                OFS_ROUTB: begin
                    prdata = rout_rd[1];
                    rout_we[1] = wr;
                end
                default: prdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/mpic_ack_route.sv
module mpic_ack_route
    import mpic_pkg::*;
#(
    parameter int NINST = 4,
    parameter int NCPU  = 4,
    parameter int IW    = 2
) (
    input  logic [NCPU-1:0][IW-1:0]  sel,
    input  logic [NCPU-1:0]          ack,
    input  logic [NCPU*NUM_W-1:0]    ack_num,
    input  linenum_t [NINST-1:0]     inst_irl,
    output linevec_t [NINST-1:0]     ack_clr,
    output logic [NCPU*NUM_W-1:0]    cpu_irl
);

    always_comb begin
        ack_clr = '0;
        for (int c = 0; c < NCPU; c++) begin
            if (ack[c]) begin
                ack_clr[sel[c]] = ack_clr[sel[c]] | line_onehot(ack_num[c*NUM_W +: NUM_W]);
            end
        end
    end

    always_comb begin
        for (int c = 0; c < NCPU; c++) begin
            cpu_irl[c*NUM_W +: NUM_W] = inst_irl[sel[c]];
        end
    end

endmodule

// File: rtl/mpic_top.sv
module mpic_top
    import mpic_pkg::*;
#(
    parameter int NINST  = 4,
    parameter int NCPU   = 4,
    parameter int ADDR_W = INST_LSB + $clog2(NINST)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   psel,
    input  logic                   penable,
    input  logic                   pwrite,
    input  logic [ADDR_W-1:0]      paddr,
    input  logic [31:0]            pwdata,
    output logic [31:0]            prdata,
    input  logic [LINE_W-1:0]      irq_in,
    input  logic [NCPU-1:0]        cpu_ack,
    input  logic [NCPU*NUM_W-1:0]  cpu_ack_num,
    output logic [NCPU*NUM_W-1:0]  cpu_irl
);

    localparam int IW = $clog2(NINST);

    inst_wr_t [NINST-1:0]    inst_wr;
    linevec_t [NINST-1:0]    pend_all;
    linevec_t [NINST-1:0]    mask_all;
    linevec_t [NINST-1:0]    group_all;
    linevec_t [NINST-1:0]    ack_clr;
    linenum_t [NINST-1:0]    inst_irl;
    logic [NCPU-1:0][IW-1:0] sel_q;
    logic                    lock_q;
    logic [1:0][31:0]        rout_rd;
    logic [1:0]              rout_we;
    logic                    ctrl_we;

    mpic_apb_dec #(.NINST(NINST), .IW(IW), .ADDR_W(ADDR_W)) u_dec (
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .pend(pend_all), .mask(mask_all), .group(group_all), .lock(lock_q), .rout_rd(rout_rd),
        .inst_wr(inst_wr), .rout_we(rout_we), .ctrl_we(ctrl_we), .prdata(prdata)
    );

    mpic_route_regs #(.NINST(NINST), .NCPU(NCPU), .IW(IW)) u_route (
        .clk(clk), .rst(rst), .rout_we(rout_we), .ctrl_we(ctrl_we), .wdata(pwdata),
        .sel_q(sel_q), .lock_q(lock_q), .rout_rd(rout_rd)
    );

    for (genvar i = 0; i < NINST; i++) begin : g_inst
        mpic_inst u_inst (
            .clk(clk), .rst(rst), .wr(inst_wr[i]), .irq_in(irq_in), .ack_clr(ack_clr[i]),
            .pend_q(pend_all[i]), .mask_q(mask_all[i]), .group_q(group_all[i]), .irl(inst_irl[i])
        );
    end

    mpic_ack_route #(.NINST(NINST), .NCPU(NCPU), .IW(IW)) u_ackr (
        .sel(sel_q), .ack(cpu_ack), .ack_num(cpu_ack_num), .inst_irl(inst_irl),
        .ack_clr(ack_clr), .cpu_irl(cpu_irl)
    );

endmodule

// File: rtl/mpic_checker.sv
module mpic_checker
    import mpic_pkg::*;
#(
    parameter int NINST = 4,
    parameter int NCPU  = 4,
    parameter int IW    = 2
) (
    input logic                     clk,
    input logic                     rst,
    input logic [LINE_W-1:0]        irq_in,
    input logic [NCPU-1:0]          cpu_ack,
    input logic [NCPU*NUM_W-1:0]    cpu_ack_num,
    input logic [NCPU*NUM_W-1:0]    cpu_irl,
    input logic [NCPU-1:0][IW-1:0]  sel_q,
    input logic                     lock_q,
    input linevec_t [NINST-1:0]     pend_all,
    input linevec_t [NINST-1:0]     mask_all
);

    linevec_t [NINST-1:0] want_clr;
    logic [NCPU-1:0]      irl_live;
    linevec_t             evt;

    assign evt = irq_in & ~linevec_t'(1);

    always_comb begin
        want_clr = '0;
        for (int i = 0; i < NINST; i++) begin
            for (int c = 0; c < NCPU; c++) begin
                if (cpu_ack[c] && int'(sel_q[c]) == i && cpu_ack_num[c*NUM_W +: NUM_W] != '0)
                    want_clr[i][cpu_ack_num[c*NUM_W +: NUM_W]] = 1'b1;
            end
        end
    end

    always_comb begin
        for (int c = 0; c < NCPU; c++) begin
            irl_live[c] = pend_all[sel_q[c]][cpu_irl[c*NUM_W +: NUM_W]] &&
                          mask_all[sel_q[c]][cpu_irl[c*NUM_W +: NUM_W]];
        end
    end

    AST_ROUTE_AT_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (sel_q == '0 && !lock_q)); // R1

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> lock_q); // R9

    AST_ROUTE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> $stable(sel_q)); // R9

    for (genvar i = 0; i < NINST; i++) begin : g_ichk
        AST_EVENT_RECORDED: assert property (@(posedge clk) disable iff (rst)
            evt != '0 |=> (pend_all[i] & $past(evt)) == $past(evt)); // R4

        AST_ACK_RETIRES: assert property (@(posedge clk) disable iff (rst)
            want_clr[i] != '0 |=> (pend_all[i] & $past(want_clr[i] & ~evt)) == '0); // R8
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_cchk
        AST_REQUEST_LIVE: assert property (@(posedge clk) disable iff (rst)
            cpu_irl[c*NUM_W +: NUM_W] != '0 |-> irl_live[c]); // R5
    end

endmodule

bind mpic_top mpic_checker #(.NINST(NINST), .NCPU(NCPU), .IW(IW)) u_chk (
    .clk(clk), .rst(rst), .irq_in(irq_in), .cpu_ack(cpu_ack), .cpu_ack_num(cpu_ack_num),
    .cpu_irl(cpu_irl), .sel_q(sel_q), .lock_q(lock_q), .pend_all(pend_all), .mask_all(mask_all)
);

// File: tb/tb_mpic_top.sv
module tb_mpic_top;

    localparam int NINST = 4;
    localparam int NCPU  = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [13:0]        paddr = '0;
    logic [31:0]        pwdata = '0;
    logic [31:0]        prdata;
    logic [15:0]        irq_in = '0;
    logic [NCPU-1:0]    cpu_ack = '0;
    logic [NCPU*4-1:0]  cpu_ack_num = '0;
    logic [NCPU*4-1:0]  cpu_irl;

    int vectors = 0;
    int fails = 0;
    bit done = 0;

    logic [15:0] m_pend [NINST];
    logic [15:0] m_mask [NINST];
    logic [15:0] m_grp  [NINST];
    int          m_sel  [NCPU];
    bit          m_lock;

    mpic_top #(.NINST(NINST), .NCPU(NCPU)) dut (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq_in(irq_in),
        .cpu_ack(cpu_ack), .cpu_ack_num(cpu_ack_num), .cpu_irl(cpu_irl)
    );

    always #4 clk = ~clk;

    function automatic logic [3:0] ref_req(int i);
        logic [15:0] live;
        live = m_pend[i] & m_mask[i];
        for (int b = 15; b >= 1; b--) if (live[b] && m_grp[i][b]) return 4'(b);
        for (int b = 15; b >= 1; b--) if (live[b]) return 4'(b);
        return 4'd0;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [13:0] addr_of(int inst, int ofs);
        return {2'(inst), 12'(ofs)};
    endfunction

    task automatic model_write(logic [13:0] a, logic [31:0] d);
        int i;
        i = int'(a[13:12]);
        case (a[11:0])
            12'h000: m_grp[i]  = d[15:0] & 16'hFFFE;
            12'h008: m_mask[i] = d[15:0] & 16'hFFFE;
            12'h00C: m_pend[i] = m_pend[i] & ~d[15:0];
            12'h010: if (d[31]) m_lock = 1;
            12'h014, 12'h018: begin
                for (int f = 0; f < 8; f++) begin
                    int c;
                    c = f + ((a[11:0] == 12'h018) ? 8 : 0);
                    if (c < NCPU && !m_lock && int'(d[f*4 +: 4]) < NINST) m_sel[c] = int'(d[f*4 +: 4]);
                end
            end
            default: ;
        endcase
    endtask

    task automatic apb_write(logic [13:0] a, logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1;
        @(negedge clk);
        psel = 0; penable = 0; pwrite = 0;
        model_write(a, d);
    endtask

    task automatic apb_read(logic [13:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1; pwrite = 0; penable = 0; paddr = a;
        @(negedge clk);
        penable = 1;
        #1 d = prdata;
        @(negedge clk);
        psel = 0; penable = 0;
    endtask

    task automatic cycle(logic [15:0] irq, logic [NCPU-1:0] ack, logic [NCPU*4-1:0] num);
        @(negedge clk);
        irq_in = irq; cpu_ack = ack; cpu_ack_num = num;
        @(negedge clk);
        irq_in = '0; cpu_ack = '0; cpu_ack_num = '0;
        for (int c = 0; c < NCPU; c++) begin
            if (ack[c] && num[c*4 +: 4] != 0) m_pend[m_sel[c]][num[c*4 +: 4]] = 1'b0;
        end
        for (int i = 0; i < NINST; i++) m_pend[i] = m_pend[i] | (irq & 16'hFFFE);
    endtask

    task automatic check_irl(string tag);
        for (int c = 0; c < NCPU; c++) check(tag, 32'(cpu_irl[c*4 +: 4]), 32'(ref_req(m_sel[c])));
    endtask

    task automatic check_pend(string tag);
        logic [31:0] d;
        for (int i = 0; i < NINST; i++) begin
            apb_read(addr_of(i, 12'h004), d);
            check(tag, d, {16'b0, m_pend[i]});
        end
    endtask

    function automatic logic [31:0] sel_word();
        logic [31:0] w;
        w = '0;
        for (int c = 0; c < NCPU && c < 8; c++) w[c*4 +: 4] = 4'(m_sel[c]);
        return w;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'h5EED_0740));
        for (int i = 0; i < NINST; i++) begin m_pend[i] = 0; m_mask[i] = 0; m_grp[i] = 0; end
        for (int c = 0; c < NCPU; c++) m_sel[c] = 0;
        m_lock = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state
        check_irl("R1 irl after reset");
        check_pend("R1 pending after reset");
        apb_read(addr_of(0, 12'h014), d); check("R1 routing after reset", d, 32'h0);
        // R2 capability
        apb_read(addr_of(2, 12'h010), d); check("R2 control read", d, 32'h0000_0003);

        // R4 line 0 ignored, others recorded everywhere
        cycle(16'h0001, '0, '0); check_pend("R4 line0 ignored");
        cycle(16'h8004, '0, '0); check_pend("R4 event in all instances");
        check_irl("R5 all masked");

        // R3 window isolation
        apb_write(addr_of(1, 12'h008), 32'h0000_FFFF);
        apb_read(addr_of(1, 12'h008), d); check("R3 mask inst1", d, 32'h0000_FFFE);
        apb_read(addr_of(0, 12'h008), d); check("R3 mask inst0 untouched", d, 32'h0);
        apb_read(addr_of(0, 12'h020), d); check("R3 unmapped offset", d, 32'h0);

        // R6 route cpu1 to instance 1
        apb_write(addr_of(0, 12'h014), 32'h0000_0010);
        check_irl("R6 routed request");
        check("R6 cpu1 sees 15", 32'(cpu_irl[7:4]), 32'd15);
        // R5 high group
        apb_write(addr_of(1, 12'h000), 32'h0000_0004);
        check("R5 group bit wins", 32'(cpu_irl[7:4]), 32'd2);
        // R8 ack clears routed instance only
        cycle(16'h0, 4'b0010, 16'h0020);
        check_pend("R8 ack only routed instance");
        check("R8 next request", 32'(cpu_irl[7:4]), 32'd15);
        // R7 invalid field
        apb_write(addr_of(0, 12'h014), 32'h0000_0215);
        apb_read(addr_of(0, 12'h014), d); check("R7 invalid field kept", d, 32'h0000_0210);
        // R11 shared instance
        apb_write(addr_of(0, 12'h014), 32'h0000_1210);
        check("R11 cpu3 shares", 32'(cpu_irl[15:12]), 32'(cpu_irl[7:4]));
        cycle(16'h0, 4'b1000, 16'hF000);
        check_irl("R11 ack from peer");
        check("R11 cpu1 retired", 32'(cpu_irl[7:4]), 32'd0);
        // R10 clear register, pend write ignored
        apb_write(addr_of(0, 12'h00C), 32'h0000_8000);
        apb_write(addr_of(0, 12'h004), 32'h0000_FFFF);
        check_pend("R10 clear and pend write");
        // R8 same-edge event wins
        apb_write(addr_of(1, 12'h000), 32'h0);
        cycle(16'h0100, '0, '0);
        cycle(16'h0100, 4'b0010, 16'h0080);
        check_pend("R8 event beats ack");
        check_irl("R8 event beats ack irl");

        // random traffic (R5 R6 R7 R8 R10 R11)
        for (int n = 0; n < 400; n++) begin
            int op;
            op = int'($urandom_range(0, 5));
            case (op)
                0, 1: begin
                    logic [NCPU-1:0] ak;
                    logic [NCPU*4-1:0] nm;
                    for (int c = 0; c < NCPU; c++) begin
                        ak[c] = 1'($urandom_range(0, 1));
                        nm[c*4 +: 4] = ($urandom_range(0, 3) == 0) ? 4'($urandom) : cpu_irl[c*4 +: 4];
                    end
                    cycle(16'($urandom) & 16'($urandom), ak, nm);
                end
                2: apb_write(addr_of(int'($urandom_range(0, 3)), 12'h000), $urandom);
                3: apb_write(addr_of(int'($urandom_range(0, 3)), 12'h008), $urandom);
                4: apb_write(addr_of(int'($urandom_range(0, 3)), 12'h00C), $urandom & $urandom);
                default: apb_write(addr_of(0, 12'h014), $urandom);
            endcase
            check_irl("R5 random request");
            if (n % 25 == 0) begin
                check_pend("R8 random pending");
                apb_read(addr_of(3, 12'h014), d); check("R6 random routing", d, sel_word());
            end
        end

        // R9 lock
        apb_write(addr_of(0, 12'h014), 32'h0000_3210);
        apb_write(addr_of(1, 12'h010), 32'h8000_0000);
        apb_read(addr_of(0, 12'h010), d); check("R9 lock flag", d, 32'h8000_0003);
        apb_write(addr_of(0, 12'h014), 32'h0000_0000);
        apb_read(addr_of(0, 12'h014), d); check("R9 routing frozen", d, 32'h0000_3210);
        apb_write(addr_of(0, 12'h010), 32'h0000_0000);
        apb_read(addr_of(0, 12'h010), d); check("R9 lock not clearable", d, 32'h8000_0003);
        check_irl("R9 requests after lock");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule